// File: doc/BRIEF.md
# Display Latch Decoder with Read-Snooped Column Loading

This block sits beside an 8-bit microcontroller's external memory bus (16-bit address, 8-bit data, active-low read and write strobes) and turns a 2 KB address window into 256 select lines. Most of those selects point at column latches, one byte per dot-matrix tile. Each column select shares its address with a location in the font memory. When the processor reads a font byte, the matching column latch snoops the byte that memory drives onto the data bus. One memory read therefore fetches the font data and also refreshes the display column.

The top 16 selects address row-drive latches. These load on ordinary write cycles. The font memory must stay off the bus for those addresses, so the block drives a memory inhibit and its complement, a memory enable. Address bits 8 to 10 are not part of the select. They act as the row number inside a tile, so each latch responds at eight addresses spaced 0x100 apart, and the window holds exactly one frame.

All strobes are sampled in the system clock domain. A latch loads on the clock in which its strobe is seen going from low to high. It takes the data and address that were registered while the strobe was low.

Top module: `disp_snoop_latch`

## Requirements
- R1: A synchronous active-high reset clears every column byte and every row byte to zero.
- R2: A read strobe pulse (rdN low, then high) at an address below 0x0800 whose low byte is below 240 loads column latch [addr[7:0]] with the last bus byte seen while rdN was low. The new value appears on colBytes[8*i +: 8] in the clock after the clock that first samples rdN high.
- R3: Address bits 8 to 10 do not take part in the select, so reads of 0x0005 and 0x0705 both load column latch 5.
- R4: A read or write at any address of 0x0800 or above changes no column byte and no row byte.
- R5: A read of an in-window address whose low byte is 240 to 255 changes no column byte and no row byte.
- R6: A write strobe pulse at an in-window address with low byte 240+k (k = 0..15) loads row byte k (rowBytes[8*k +: 8]) with the last bus byte seen while wrN was low.
- R7: A write to a column-select address changes no column byte.
- R8: memInhibit is 1 exactly when the address is below 0x0800 and its low byte is 240 or above. memCe is always the complement of memInhibit.
- R9: While a strobe is still low no latch changes. Bus data that changes at or after the rising strobe is not captured.
- R10: At most one latch loads in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 16 | Processor address bus |
| busData | input | 8 | Data bus (font memory output on reads, processor output on writes) |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| memCe | output | 1 | Font memory enable, high except for row-latch addresses |
| memInhibit | output | 1 | High for in-window row-latch addresses |
| colBytes | output | 1920 | Column latch bytes, tile i at bits [8*i +: 8] |
| rowBytes | output | 128 | Row latch bytes, row k at bits [8*k +: 8] |

## Verification
The hardest case to reach is a capture that depends on when the data bus changes relative to the strobe edge: the latch must take the byte held while the strobe was low, not the one present once it rises. Every bus cycle in the bench therefore flips the data bus to its inverse in the same instant the strobe goes high. It also checks mid-strobe that nothing has loaded yet. Random addresses are weighted toward aliases that differ only in bits 8 to 10, toward the 240/255 select boundary, and toward just-outside-window values such as 0x08xx. This way the column, row and ignored paths each get many hits with distinct font bytes.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int SEL_W   = 8;
  localparam int ALIAS_W = 3;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int WINDOW  = 1 << (SEL_W + ALIAS_W);

  typedef struct packed {
    logic              colLoad;
    logic              rowLoad;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } latch_ctl_t;
endpackage

// File: rtl/dsl_decode.sv
module dsl_decode
  import dsl_pkg::*;
#(
  parameter int NUM_COLS = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [SEL_W-1:0]  sel,
  output logic              isCol,
  output logic              isRow,
  output logic              memCe,
  output logic              memInhibit
);
  logic inWindow;
  logic upperSel;

  always_comb begin
    inWindow   = (32'(busAddr) < WINDOW);
    sel        = busAddr[SEL_W-1:0];
    upperSel   = (32'(sel) >= NUM_COLS);
    isCol      = inWindow && !upperSel;
    isRow      = inWindow && upperSel;
    memInhibit = isRow;
    memCe      = !isRow;
  end

  // R8
  inhibit_window_chk: assert property (@(posedge clk) disable iff (rst)
    memInhibit |-> (busAddr[ADDR_W-1:SEL_W+ALIAS_W] == '0 && 32'(busAddr[SEL_W-1:0]) >= NUM_COLS));
  // R8
  ce_complement_chk: assert property (@(posedge clk) disable iff (rst)
    memCe != memInhibit);
endmodule

// File: rtl/dsl_ctrl.sv
module dsl_ctrl
  import dsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busData,
  input  logic [SEL_W-1:0]  sel,
  input  logic              isCol,
  input  logic              isRow,
  output latch_ctl_t        ctl
);
  logic              rdQ, wrQ;
  logic [DATA_W-1:0] holdData;
  logic [SEL_W-1:0]  holdSel;
  logic              holdCol, holdRow;
  logic              rdRise, wrRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdQ      <= 1'b1;
      wrQ      <= 1'b1;
      holdData <= '0;
      holdSel  <= '0;
      holdCol  <= 1'b0;
      holdRow  <= 1'b0;
    end else begin
      rdQ <= rdN;
      wrQ <= wrN;
      if (!rdN || !wrN) begin
        holdData <= busData;
        holdSel  <= sel;
        holdCol  <= isCol;
        holdRow  <= isRow;
      end
    end
  end

  always_comb begin
    rdRise      = rdN && !rdQ;
    wrRise      = wrN && !wrQ;
    ctl.colLoad = rdRise && holdCol;
    ctl.rowLoad = wrRise && !rdRise && holdRow;
    ctl.sel     = holdSel;
    ctl.data    = holdData;
  end

  // R9
  col_after_low_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.colLoad |-> (rdN && $past(!rdN)));
  // R6
  row_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.rowLoad |-> (wrN && $past(!wrN)));
endmodule

// File: rtl/dsl_datapath.sv
module dsl_datapath
  import dsl_pkg::*;
#(
  parameter int NUM_COLS = 240
) (
  input  logic                         clk,
  input  logic                         rst,
  input  latch_ctl_t                   ctl,
  output logic [NUM_COLS*DATA_W-1:0]   colBytes,
  output logic [(NUM_SEL-NUM_COLS)*DATA_W-1:0] rowBytes
);
  localparam int NUM_ROWS = NUM_SEL - NUM_COLS;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst)
        colBytes[c*DATA_W +: DATA_W] <= '0;
      else if (ctl.colLoad && 32'(ctl.sel) == c)
        colBytes[c*DATA_W +: DATA_W] <= ctl.data;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        rowBytes[r*DATA_W +: DATA_W] <= '0;
      else if (ctl.rowLoad && 32'(ctl.sel) == NUM_COLS + r)
        rowBytes[r*DATA_W +: DATA_W] <= ctl.data;
    end
  end

  // R10
  one_load_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl.colLoad && ctl.rowLoad));
  // R4
  col_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.colLoad |=> $stable(colBytes));
  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.rowLoad |=> $stable(rowBytes));
endmodule

// File: rtl/disp_snoop_latch.sv
module disp_snoop_latch
  import dsl_pkg::*;
#(
  parameter int NUM_COLS = 240
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [ADDR_W-1:0]                     busAddr,
  input  logic [DATA_W-1:0]                     busData,
  input  logic                                  rdN,
  input  logic                                  wrN,
  output logic                                  memCe,
  output logic                                  memInhibit,
  output logic [NUM_COLS*DATA_W-1:0]            colBytes,
  output logic [(NUM_SEL-NUM_COLS)*DATA_W-1:0]  rowBytes
);
  logic [SEL_W-1:0] sel;
  logic             isCol, isRow;
  latch_ctl_t       ctl;

  dsl_decode #(.NUM_COLS(NUM_COLS)) u_decode (
    .clk(clk), .rst(rst), .busAddr(busAddr), .sel(sel),
    .isCol(isCol), .isRow(isRow), .memCe(memCe), .memInhibit(memInhibit)
  );

  dsl_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rdN(rdN), .wrN(wrN), .busData(busData),
    .sel(sel), .isCol(isCol), .isRow(isRow), .ctl(ctl)
  );

  dsl_datapath #(.NUM_COLS(NUM_COLS)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .colBytes(colBytes), .rowBytes(rowBytes)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (colBytes == '0 && rowBytes == '0));
endmodule

// File: tb/disp_snoop_latch_tb.sv
module disp_snoop_latch_tb;
  localparam int COLS = 240;
  localparam int ROWS = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [15:0]          busAddr = 16'hFFFF;
  logic [7:0]           busData = 8'h00;
  logic                 rdN = 1'b1;
  logic                 wrN = 1'b1;
  logic                 memCe, memInhibit;
  logic [COLS*8-1:0]    colBytes;
  logic [ROWS*8-1:0]    rowBytes;

  logic [7:0] colExp [COLS];
  logic [7:0] rowExp [ROWS];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  disp_snoop_latch #(.NUM_COLS(COLS)) u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busData(busData),
    .rdN(rdN), .wrN(wrN), .memCe(memCe), .memInhibit(memInhibit),
    .colBytes(colBytes), .rowBytes(rowBytes)
  );

  function automatic logic [7:0] fontByte(input logic [15:0] a);
    return 8'((a * 37) ^ (a >> 3) ^ 16'h5A);
  endfunction

  function automatic bit isColAddr(input logic [15:0] a);
    return a < 16'h0800 && a[7:0] < 8'(COLS);
  endfunction

  function automatic bit isRowAddr(input logic [15:0] a);
    return a < 16'h0800 && a[7:0] >= 8'(COLS);
  endfunction

  task automatic compareAll(input string tag);
    bit bad = 0;
    checks++;
    for (int c = 0; c < COLS; c++)
      if (!bad && colBytes[c*8 +: 8] !== colExp[c]) begin
        $display("FAIL %s col %0d actual=%02h expected=%02h", tag, c, colBytes[c*8 +: 8], colExp[c]);
        bad = 1;
      end
    for (int r = 0; r < ROWS; r++)
      if (!bad && rowBytes[r*8 +: 8] !== rowExp[r]) begin
        $display("FAIL %s row %0d actual=%02h expected=%02h", tag, r, rowBytes[r*8 +: 8], rowExp[r]);
        bad = 1;
      end
    if (bad) errors++;
  endtask

  task automatic checkDecode(input logic [15:0] a);
    logic expInh;
    expInh = isRowAddr(a);
    checks++;
    if (memInhibit !== expInh || memCe !== !expInh) begin
      errors++;
      $display("FAIL R8 addr=%04h actual inh=%b ce=%b expected inh=%b ce=%b",
               a, memInhibit, memCe, expInh, !expInh);
    end
  endtask

  // one bus cycle: strobe low two clocks, data flips as strobe rises
  task automatic busCycle(input bit isRead, input logic [15:0] a, input logic [7:0] wdata, input string tag);
    logic [7:0] d;
    @(negedge clk);
    busAddr = a;
    d = isRead ? (isRowAddr(a) ? 8'hEE : fontByte(a)) : wdata;
    busData = d;
    if (isRead) rdN = 1'b0; else wrN = 1'b0;
    @(negedge clk);
    checkDecode(a);
    compareAll("R9 mid-strobe");
    @(negedge clk);
    busData = ~d;
    rdN = 1'b1;
    wrN = 1'b1;
    @(negedge clk);
    busAddr = 16'hFFFF;
    if (isRead && isColAddr(a)) colExp[a[7:0]] = d;
    if (!isRead && isRowAddr(a)) rowExp[a[7:0] - 8'(COLS)] = d;
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic clearExp();
    for (int c = 0; c < COLS; c++) colExp[c] = 8'h00;
    for (int r = 0; r < ROWS; r++) rowExp[r] = 8'h00;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] a;
    int kind;
    void'($urandom(32'd1234));
    clearExp();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compareAll("R1 reset");

    busCycle(1, 16'h0005, 8'h00, "R2 column read");
    busCycle(1, 16'h0705, 8'h00, "R3 alias read");
    busCycle(1, 16'h00EF, 8'h00, "R2 last column");
    busCycle(1, 16'h0805, 8'h00, "R4 out-of-window read");
    busCycle(0, 16'hF8F3, 8'h77, "R4 out-of-window write");
    busCycle(1, 16'h00F3, 8'h00, "R5 row-select read");
    busCycle(0, 16'h03F3, 8'hA5, "R6 row write");
    busCycle(0, 16'h00F0, 8'h3C, "R6 first row");
    busCycle(0, 16'h07FF, 8'hC3, "R6 last row");
    busCycle(0, 16'h0312, 8'h99, "R7 write to column");

    for (int i = 0; i < 300; i++) begin
      kind = $urandom_range(0, 5);
      a = 16'($urandom);
      case (kind)
        0, 1: a = {5'b0, a[10:8], 8'($urandom_range(0, COLS - 1))};
        2:    a = {5'b0, a[10:8], 8'($urandom_range(COLS, 255))};
        3:    a = {5'b00001, a[10:0]};
        default: ;
      endcase
      if ($urandom_range(0, 1) == 0)
        busCycle(1, a, 8'h00, isColAddr(a) ? "R2 random read" : "R5 random ignored read");
      else
        busCycle(0, a, 8'($urandom), isRowAddr(a) ? "R6 random write" : "R7 random ignored write");
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    clearExp();
    compareAll("R1 reset after traffic");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule